// File: doc/BRIEF.md
# Strobe-Driven Rewindable FIFO with Token Cascade

This block is a 9-bit first-in first-out buffer whose write and read sides are driven by active-low strobes. Both strobes are sampled on one system clock, and an access happens once, at the strobe's falling edge. The block reports empty, full and more-than-half-full status. It can also rewind its read side to address 0, so a stored message can be read again from its first word.

In cascade mode, several instances share the strobes and form one deeper buffer. Each instance keeps a write token and a read token. An instance answers a strobe only while it holds the matching token. When its write or read pointer runs off the last location, it gives that token up and pulses its expansion output for one clock. The next instance takes the pulse on its expansion input. In this mode the half-full pin carries the expansion pulse. A first-load input picks the instance that holds both tokens after reset.

Top module: `rewind_fifo`

## Requirements
- R1: Words are 9 bits wide. A falling edge of `wr_n` stores `din`. A falling edge of `rd_n` places the oldest unread word on `dout` by the next clock. Words leave in the order they arrived.
- R2: `dout_en` is 1 exactly while `rd_n` is low.
- R3: `full` is 1 when DEPTH words are held. A write edge while full is ignored: nothing is overwritten and the count does not move.
- R4: `empty` is 1 when no words are held. A read edge while empty is ignored: `dout` keeps its previous value.
- R5: In standalone mode (`cascade`=0), `hf_xo` is 1 exactly when more than DEPTH/2 words are held.
- R6: In standalone mode, `rt_n` low while `wr_n` and `rd_n` are both high rewinds the read pointer to address 0. The held count becomes the number of words written since reset, below DEPTH. Reads then replay from the first word. With either strobe low, `rt_n` has no effect.
- R7: After reset, `empty`=1, `full`=0, `hf_xo`=0 and `dout`=0.
- R8: In cascade mode, `hf_xo` pulses high for exactly one clock after a write to location DEPTH-1, and likewise after a read from location DEPTH-1. The instance then ignores further write (or read) edges until it is granted that token again.
- R9: In cascade mode, `first_load`=1 at reset gives this instance both tokens. With `first_load`=0, every strobe is ignored until a token is granted.
- R10: A rising edge on `xi` grants the read token if words are held and the read token is absent. Otherwise it grants the write token if that is absent.
- R11: A strobe held low over many clocks performs only one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| cascade | input | 1 | 1 = depth-cascade mode, 0 = standalone |
| first_load | input | 1 | Selects the token holder after reset (cascade mode) |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Retransmit request, active low |
| xi | input | 1 | Expansion-in token pulse |
| din | input | 9 | Write data |
| dout | output | 9 | Read data |
| dout_en | output | 1 | Output enable, stands in for the tri-state driver |
| empty | output | 1 | No words held |
| full | output | 1 | DEPTH words held |
| hf_xo | output | 1 | Half-full (standalone) or expansion-out pulse (cascade) |

## Verification
The main data path is driven with a long random mix of write and read edges, run against a queue model. This shows that ordering, counting and the flags agree across many fill levels and wrap-arounds. A directed fill to capacity and back separates the half-full threshold at DEPTH/2 from DEPTH/2+1, and shows that a refused write leaves stored data intact. Retransmit is tried twice: once with both strobes idle, where it must replay from the first word, and once with a write strobe low, where it must leave the read position alone. The cascade runs check that tokens are given up at each wrap, that `xi` grants tokens in the stated order, and that an instance without tokens does not respond.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
  // strobe index inside the edge detector vector
  localparam int EDGE_WR = 0;
  localparam int EDGE_RD = 1;
  localparam int EDGE_XI = 2;
  localparam int EDGE_N  = 3;
endpackage

// File: rtl/rwf_reset_sync.sv
module rwf_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/rwf_strobe_edge.sv
module rwf_strobe_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_d;
    assign prev_d  = lvl_n[i];
    assign fall[i] = prev_q[i] & ~lvl_n[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b1;
      end else begin
        prev_q[i] <= prev_d;
      end
    end
  end
endmodule

// File: rtl/rwf_ptr_ctrl.sv
module rwf_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  logic          rd_go,
  input  logic          rewind,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] cnt,
  output logic          empty,
  output logic          full,
  output logic          half,
  output logic          wr_wrap,
  output logic          rd_wrap
);
  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP    = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_T = CW'(DEPTH / 2);

  logic [AW-1:0] wr_ptr_d, rd_ptr_d;
  logic [CW-1:0] cnt_d;
  logic          ptr_ce;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CAP);
  assign half    = (cnt > HALF_T);
  assign wr_en   = wr_go & ~full;
  assign rd_en   = rd_go & ~empty;
  assign wr_wrap = wr_en & (wr_ptr == LAST);
  assign rd_wrap = rd_en & (rd_ptr == LAST);
  assign ptr_ce  = wr_en | rd_en | rewind;

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    cnt_d    = cnt;
    if (wr_en) begin
      wr_ptr_d = wr_wrap ? '0 : wr_ptr + 1'b1;
    end
    if (rd_en) begin
      rd_ptr_d = rd_wrap ? '0 : rd_ptr + 1'b1;
    end
    unique case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt + 1'b1;
      2'b01:   cnt_d = cnt - 1'b1;
      default: cnt_d = cnt;
    endcase
    if (rewind) begin
      rd_ptr_d = '0;
      cnt_d    = CW'(wr_ptr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (ptr_ce) begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      cnt    <= cnt_d;
    end
  end
endmodule

// File: rtl/rwf_store.sv
module rwf_store
  import rewind_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  word_t         wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output word_t         rd_data
);
  word_t mem [DEPTH];
  word_t rd_data_d;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data_d = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_data_d;
    end
  end
endmodule

// File: rtl/rwf_token.sv
module rwf_token (
  input  logic clk,
  input  logic rst_n,
  input  logic cascade,
  input  logic first_load,
  input  logic xi_rise,
  input  logic has_data,
  input  logic wr_wrap,
  input  logic rd_wrap,
  output logic wr_ok,
  output logic rd_ok,
  output logic xo
);
  logic wtok_q, rtok_q, loaded_q, xo_q;
  logic wtok_d, rtok_d, xo_d;

  always_comb begin
    wtok_d = wtok_q;
    rtok_d = rtok_q;
    if (!loaded_q) begin
      wtok_d = first_load;
      rtok_d = first_load;
    end else begin
      if (wr_wrap) wtok_d = 1'b0;
      if (rd_wrap) rtok_d = 1'b0;
      if (xi_rise) begin
        if (has_data && !rtok_q) begin
          rtok_d = 1'b1;
        end else if (!wtok_q) begin
          wtok_d = 1'b1;
        end
      end
    end
    xo_d = cascade & (wr_wrap | rd_wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wtok_q   <= 1'b0;
      rtok_q   <= 1'b0;
      loaded_q <= 1'b0;
      xo_q     <= 1'b0;
    end else begin
      wtok_q   <= wtok_d;
      rtok_q   <= rtok_d;
      loaded_q <= 1'b1;
      xo_q     <= xo_d;
    end
  end

  assign wr_ok = ~cascade | (loaded_q & wtok_q);
  assign rd_ok = ~cascade | (loaded_q & rtok_q);
  assign xo    = xo_q;
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rewind_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cascade,
  input  logic              first_load,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              rt_n,
  input  logic              xi,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en,
  output logic              empty,
  output logic              full,
  output logic              hf_xo
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic              srst_n;
  logic [EDGE_N-1:0] lvl_n, fall;
  logic              wr_ok, rd_ok, wr_en, rd_en, rewind;
  logic              half, wr_wrap, rd_wrap, xo;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt;

  rwf_reset_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    lvl_n          = '1;
    lvl_n[EDGE_WR] = wr_n;
    lvl_n[EDGE_RD] = rd_n;
    lvl_n[EDGE_XI] = ~xi;
  end

  rwf_strobe_edge #(.N(EDGE_N)) u_edge (
    .clk   (clk),
    .rst_n (srst_n),
    .lvl_n (lvl_n),
    .fall  (fall)
  );

  assign rewind = ~cascade & ~rt_n & wr_n & rd_n;

  rwf_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_go   (fall[EDGE_WR] & wr_ok),
    .rd_go   (fall[EDGE_RD] & rd_ok),
    .rewind  (rewind),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .cnt     (cnt),
    .empty   (empty),
    .full    (full),
    .half    (half),
    .wr_wrap (wr_wrap),
    .rd_wrap (rd_wrap)
  );

  rwf_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_ptr),
    .wr_data (din),
    .rd_en   (rd_en),
    .rd_addr (rd_ptr),
    .rd_data (dout)
  );

  rwf_token u_tok (
    .clk        (clk),
    .rst_n      (srst_n),
    .cascade    (cascade),
    .first_load (first_load),
    .xi_rise    (fall[EDGE_XI]),
    .has_data   (~empty),
    .wr_wrap    (wr_wrap),
    .rd_wrap    (rd_wrap),
    .wr_ok      (wr_ok),
    .rd_ok      (rd_ok),
    .xo         (xo)
  );

  assign hf_xo   = cascade ? xo : half;
  assign dout_en = ~rd_n;
endmodule

// File: rtl/rwf_checker.sv
module rwf_checker #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cascade,
  input logic          wr_n,
  input logic          rd_n,
  input logic          rt_n,
  input logic          empty,
  input logic          full,
  input logic          hf_xo,
  input logic [CW-1:0] cnt,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr
);
  assert_flags_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full && rd_n && rt_n |=> full);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    empty && wr_n && rt_n |=> empty);

  assert_rewind_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cascade && !rt_n && wr_n && rd_n |=> rd_ptr == '0);

  assert_xo_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cascade && $past(cascade) && hf_xo |->
      ($past(wr_ptr) != wr_ptr) || ($past(rd_ptr) != rd_ptr));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

bind rewind_fifo rwf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (srst_n),
  .cascade (cascade),
  .wr_n    (wr_n),
  .rd_n    (rd_n),
  .rt_n    (rt_n),
  .empty   (empty),
  .full    (full),
  .hf_xo   (hf_xo),
  .cnt     (cnt),
  .wr_ptr  (wr_ptr),
  .rd_ptr  (rd_ptr)
);

// File: tb/rewind_fifo_bench.sv
`timescale 1ns/1ps
module rewind_fifo_bench;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n, cascade, first_load, wr_n, rd_n, rt_n, xi;
  logic [8:0] din, dout;
  logic       dout_en, empty, full, hf_xo;

  int total = 0;
  int bad   = 0;
  logic xo_a, xo_b, en_a, en_b;
  logic [8:0] rd_val;

  always #5 clk = ~clk;

  rewind_fifo #(.DEPTH(DEPTH)) u_rewind_fifo (
    .clk(clk), .rst_n(rst_n), .cascade(cascade), .first_load(first_load),
    .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .xi(xi), .din(din),
    .dout(dout), .dout_en(dout_en), .empty(empty), .full(full), .hf_xo(hf_xo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_half(input int n);
    return n > DEPTH / 2;
  endfunction

  task automatic apply_reset(input logic casc, input logic fl);
    @(negedge clk);
    rst_n = 1'b0; cascade = casc; first_load = fl;
    wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; xi = 1'b0; din = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input logic [8:0] d);
    wr_n = 1'b0; din = d;
    @(negedge clk); xo_a = hf_xo; wr_n = 1'b1;
    @(negedge clk); xo_b = hf_xo;
  endtask

  task automatic do_read();
    rd_n = 1'b0;
    @(negedge clk); rd_val = dout; en_a = dout_en; xo_a = hf_xo; rd_n = 1'b1;
    @(negedge clk); en_b = dout_en; xo_b = hf_xo;
  endtask

  task automatic pulse_xi();
    xi = 1'b1;
    @(negedge clk); xi = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 5) % 512);
  endfunction

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int q[$];
    logic [8:0] last;
    void'($urandom(32'd20240611));

    // reset state
    apply_reset(1'b0, 1'b1);
    chk(empty == 1'b1, "R7 empty", int'(empty), 1);
    chk(full == 1'b0, "R7 full", int'(full), 0);
    chk(hf_xo == 1'b0, "R7 hf", int'(hf_xo), 0);
    chk(dout == 9'd0, "R7 dout", int'(dout), 0);
    chk(dout_en == 1'b0, "R2 idle oe", int'(dout_en), 0);

    // read while empty is ignored
    do_read();
    chk(rd_val == 9'd0, "R4 empty read dout", int'(rd_val), 0);
    chk(empty == 1'b1, "R4 still empty", int'(empty), 1);
    chk(en_a == 1'b1 && en_b == 1'b0, "R2 oe follows rd_n", int'({en_a, en_b}), 2);

    // held strobe gives one access
    wr_n = 1'b0; din = 9'h1A5;
    repeat (4) @(negedge clk);
    wr_n = 1'b1; @(negedge clk);
    do_read();
    chk(rd_val == 9'h1A5, "R11 held write data", int'(rd_val), 'h1A5);
    chk(empty == 1'b1, "R11 single access", int'(empty), 1);

    // fill to capacity, half threshold, overflow ignored
    apply_reset(1'b0, 1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      do_write(pat(i));
      chk(hf_xo == exp_half(i + 1), "R5 half on fill", int'(hf_xo), int'(exp_half(i + 1)));
    end
    chk(full == 1'b1, "R3 full at capacity", int'(full), 1);
    do_write(9'h0FF);
    chk(full == 1'b1, "R3 still full", int'(full), 1);
    for (int i = 0; i < DEPTH; i++) begin
      do_read();
      chk(rd_val == pat(i), "R1 order after fill", int'(rd_val), int'(pat(i)));
      chk(hf_xo == exp_half(DEPTH - 1 - i), "R5 half on drain", int'(hf_xo), int'(exp_half(DEPTH - 1 - i)));
    end
    chk(empty == 1'b1, "R3 overflow word not stored", int'(empty), 1);

    // retransmit
    apply_reset(1'b0, 1'b1);
    for (int i = 0; i < 6; i++) do_write(pat(100 + i));
    for (int i = 0; i < 2; i++) do_read();
    // rewind attempt with write strobe low: write happens, rewind ignored
    wr_n = 1'b0; rt_n = 1'b0; din = pat(106);
    @(negedge clk); wr_n = 1'b1; rt_n = 1'b1;
    @(negedge clk);
    do_read();
    chk(rd_val == pat(102), "R6 rewind ignored with strobe low", int'(rd_val), int'(pat(102)));
    rt_n = 1'b0; @(negedge clk); rt_n = 1'b1; @(negedge clk);
    for (int i = 0; i < 7; i++) begin
      do_read();
      chk(rd_val == pat(100 + i), "R6 replay", int'(rd_val), int'(pat(100 + i)));
    end
    chk(empty == 1'b1, "R6 count restored", int'(empty), 1);

    // random standalone traffic against a queue model
    apply_reset(1'b0, 1'b1);
    last = 9'd0;
    for (int n = 0; n < 600; n++) begin
      bit w;
      w = (q.size() < 3) ? ($urandom % 4 != 0) : ($urandom % 2 == 1);
      if (w) begin
        logic [8:0] d;
        d = 9'($urandom % 512);
        do_write(d);
        if (q.size() < DEPTH) q.push_back(int'(d));
      end else begin
        do_read();
        if (q.size() > 0) last = 9'(q.pop_front());
        chk(rd_val == last, "R1 random data", int'(rd_val), int'(last));
      end
      chk(empty == (q.size() == 0), "R4 random empty", int'(empty), int'(q.size() == 0));
      chk(full == (q.size() == DEPTH), "R3 random full", int'(full), int'(q.size() == DEPTH));
      chk(hf_xo == exp_half(q.size()), "R5 random half", int'(hf_xo), int'(exp_half(q.size())));
    end

    // cascade with initial tokens
    apply_reset(1'b1, 1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      do_write(pat(200 + i));
      if (i < DEPTH - 1)
        chk(xo_a == 1'b0, "R8 no xo before wrap", int'(xo_a), 0);
    end
    chk(xo_a == 1'b1 && xo_b == 1'b0, "R8 xo one clock on write wrap", int'({xo_a, xo_b}), 2);
    do_read();
    chk(rd_val == pat(200), "R1 cascade first", int'(rd_val), int'(pat(200)));
    do_write(9'h111);
    chk(full == 1'b0, "R8 write ignored after wrap", int'(full), 0);
    for (int i = 1; i < DEPTH; i++) begin
      do_read();
      chk(rd_val == pat(200 + i), "R8 cascade order", int'(rd_val), int'(pat(200 + i)));
    end
    chk(xo_a == 1'b1 && xo_b == 1'b0, "R8 xo one clock on read wrap", int'({xo_a, xo_b}), 2);
    chk(empty == 1'b1, "R8 drained", int'(empty), 1);
    pulse_xi();
    do_write(9'h0C3);
    chk(empty == 1'b0, "R10 xi grants write token", int'(empty), 0);
    do_read();
    chk(rd_val == pat(215), "R8 read ignored without token", int'(rd_val), int'(pat(215)));
    pulse_xi();
    do_read();
    chk(rd_val == 9'h0C3, "R10 xi grants read token", int'(rd_val), 'h0C3);

    // cascade without initial tokens
    apply_reset(1'b1, 1'b0);
    do_write(9'h055);
    chk(empty == 1'b1, "R9 no token ignores write", int'(empty), 1);
    pulse_xi();
    do_write(9'h066);
    chk(empty == 1'b0, "R9 write after grant", int'(empty), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule